// File: doc/BRIEF.md
# Interval Tick Ignore Counter Bank

A bank of per-CPU down-counters that sits between one shared periodic interval timer and the timer-interrupt flags of up to four CPUs. Each counter is loaded by software with an ignore count. Every timer tick lowers every present CPU's counter by one. Once a counter has wrapped past zero it raises a sticky overflow bit. From then on, every tick delivers a one-cycle set pulse to that CPU's timer-interrupt flag.

The count keeps running down after overflow. Software can read it back to see how many ticks went by unreported. Writing a counter reloads the count and clears the overflow bit. The tick input is asynchronous: it is synchronised, and only its rising edge counts. The flag register that receives the set pulses and the timer that makes the ticks are outside this block.

Top module: `tick_gate_bank`

## Requirements
- R1: A write to a counter's address stores the low 24 bits of `reg_wdata` as the count and clears the overflow bit (bit 24), whatever bit 24 of the write data is.
- R2: On each tick, a present CPU's 25-bit value becomes (value − 1) mod 2^25, with bit 24 then ORed with its old value. Overflow is sticky and the count keeps decrementing.
- R3: When a tick leaves bit 24 of CPU i's value set, `timer_set[i]` is high for exactly one cycle. Bit i of the output stands for timer flag bit 4+i of that CPU.
- R4: Only a rising edge of `tick_in` is a tick. Holding it high, or letting it fall, changes no counter.
- R5: The counters of CPUs 0, 1, 2 and 3 are at byte addresses 0x380, 0x3C0, 0x700 and 0x740. `reg_rdata` returns the addressed counter's 25-bit value, including overflow, in the same cycle. Any other address reads as zero, and a write to it changes no counter.
- R6: A CPU whose `cpu_present` bit is low has its counter left unchanged by ticks, and gets no set pulse.
- R7: When a write and a tick reach the same counter in the same cycle, the write takes effect, the tick is lost for that counter, and no set pulse is sent.
- R8: After reset every counter and overflow bit is zero and `timer_set` is zero.
- R9: If `tick_in` is first sampled high at clock edge k, the counters and `timer_set` change at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_in | input | 1 | Asynchronous interval timer tick level |
| cpu_present | input | 4 | One bit per CPU; a low bit freezes that CPU's counter |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 25 | Write data; only bits 23:0 are stored |
| reg_rdata | output | 25 | Value of the addressed counter, zero for other addresses |
| timer_set | output | 4 | One-cycle set pulses toward each CPU's timer flag bit |

## Verification
The bench builds the block with its default parameters: four CPUs, a 24-bit count and 12-bit addresses. At these values all four register offsets and the presence mask can be exercised. Loading counts of 0 to 5 makes 25-bit wrap-around and sticky overflow reachable within a few ticks. Full 24-bit random loads keep the bit-24 masking on writes under test. A bench model of every counter is compared after each tick, and the collision of a write with the tick update is driven directly in the one cycle where both meet.

// File: rtl/tgate_pkg.sv
package tgate_pkg;

  // Byte offset of the counter that belongs to CPU idx. CPUs 0 and 1 sit in
  // the low block, CPUs 2 and 3 in the high block, 0x40 apart.
  function automatic int unsigned slot_addr(input int unsigned idx);
    if (idx < 2) begin
      slot_addr = 32'h380 + idx * 32'h40;
    end else begin
      slot_addr = 32'h700 + (idx - 2) * 32'h40;
    end
  endfunction

endpackage

// File: rtl/tgate_rst_sync.sv
module tgate_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/tgate_tick_sync.sv
module tgate_tick_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_async,
  output logic tick_pulse
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tick_async};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  // rising edge of the synchronised level
  assign tick_pulse = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/tgate_addr_dec.sv
module tgate_addr_dec
  import tgate_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  output logic [NUM_CPU-1:0] sel,
  output logic [NUM_CPU-1:0] wr_hit
);
  for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(slot_addr(g));
    assign sel[g]    = (addr == SLOT);
    assign wr_hit[g] = wr & sel[g];
  end
endmodule

// File: rtl/tgate_ignore_cnt.sv
module tgate_ignore_cnt #(
  parameter int unsigned CNT_W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [CNT_W:0] wdata,
  input  logic         tick,
  input  logic         present,
  output logic [CNT_W:0] value,
  output logic         set_pulse
);
  localparam int unsigned VAL_W = CNT_W + 1;
  localparam logic [VAL_W-1:0] CNT_MASK = {1'b0, {CNT_W{1'b1}}};
  localparam logic [VAL_W-1:0] OVF_MASK = {1'b1, {CNT_W{1'b0}}};

  logic [VAL_W-1:0] val_q, val_d;
  logic             set_q, set_d;
  logic             val_en;
  logic [VAL_W-1:0] dec;

  always_comb begin
    dec    = val_q - VAL_W'(1);
    val_en = wr_hit | (tick & present);
    val_d  = val_q;
    set_d  = 1'b0;
    if (wr_hit) begin
      val_d = wdata & CNT_MASK;
    end else if (tick && present) begin
      val_d = dec | (val_q & OVF_MASK);
      set_d = val_d[CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      set_q <= 1'b0;
    end else begin
      if (val_en) begin
        val_q <= val_d;
      end
      set_q <= set_d;
    end
  end

  assign value     = val_q;
  assign set_pulse = set_q;
endmodule

// File: rtl/tick_gate_bank.sv
module tick_gate_bank #(
  parameter int unsigned NUM_CPU     = 4,
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_in,
  input  logic [NUM_CPU-1:0] cpu_present,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [CNT_W:0]     reg_wdata,
  output logic [CNT_W:0]     reg_rdata,
  output logic [NUM_CPU-1:0] timer_set
);
  logic                          rst_sync_n;
  logic                          tick_pulse;
  logic [NUM_CPU-1:0]            sel;
  logic [NUM_CPU-1:0]            wr_hit;
  logic [NUM_CPU-1:0][CNT_W:0]   cnt_val;

  tgate_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  tgate_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_async (tick_in),
    .tick_pulse (tick_pulse)
  );

  tgate_addr_dec #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dec (
    .addr   (reg_addr),
    .wr     (reg_wr),
    .sel    (sel),
    .wr_hit (wr_hit)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cnt
    tgate_ignore_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_hit    (wr_hit[g]),
      .wdata     (reg_wdata),
      .tick      (tick_pulse),
      .present   (cpu_present[g]),
      .value     (cnt_val[g]),
      .set_pulse (timer_set[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (sel[i]) begin
        reg_rdata = reg_rdata | cnt_val[i];
      end
    end
  end
endmodule

// File: rtl/tick_gate_bank_chk.sv
module tick_gate_bank_chk #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CNT_W   = 24
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick_pulse,
  input logic [NUM_CPU-1:0]          wr_hit,
  input logic [NUM_CPU-1:0]          cpu_present,
  input logic [CNT_W:0]              reg_wdata,
  input logic [NUM_CPU-1:0][CNT_W:0] cnt_val,
  input logic [NUM_CPU-1:0]          timer_set
);
  // R4: an edge detector never yields two ticks in a row
  p_single_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse |=> !tick_pulse);

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_chk
    // R1: a write leaves overflow clear and the low bits of the data
    p_write_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[g] |=> (cnt_val[g] == {1'b0, $past(reg_wdata[CNT_W-1:0])}));

    // R2: overflow stays set until a write
    p_sticky_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_val[g][CNT_W] && !wr_hit[g]) |=> cnt_val[g][CNT_W]);

    // R3: a set pulse only comes with overflow set
    p_pulse_needs_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
      timer_set[g] |-> cnt_val[g][CNT_W]);

    // R3: a pulse lasts one cycle (ticks are never back to back)
    p_pulse_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      timer_set[g] |=> !timer_set[g]);

    // R6: an absent CPU keeps its value and gets no pulse
    p_absent_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_present[g] && !wr_hit[g]) |=> ($stable(cnt_val[g]) && !timer_set[g]));

    // R7: a write cycle never produces a pulse
    p_write_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[g] |=> !timer_set[g]);
  end
endmodule

bind tick_gate_bank tick_gate_bank_chk #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tick_pulse  (tick_pulse),
  .wr_hit      (wr_hit),
  .cpu_present (cpu_present),
  .reg_wdata   (reg_wdata),
  .cnt_val     (cnt_val),
  .timer_set   (timer_set)
);

// File: tb/tb_tick_gate_bank.sv
module tb_tick_gate_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_in;
  logic [3:0]  cpu_present;
  logic [11:0] reg_addr;
  logic        reg_wr;
  logic [24:0] reg_wdata;
  logic [24:0] reg_rdata;
  logic [3:0]  timer_set;

  int checks = 0;
  int errors = 0;
  logic [24:0] model [NCPU];

  tick_gate_bank dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .cpu_present(cpu_present),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .timer_set(timer_set)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] addr_of(input int idx);
    case (idx)
      0: addr_of = 12'h380;
      1: addr_of = 12'h3C0;
      2: addr_of = 12'h700;
      default: addr_of = 12'h740;
    endcase
  endfunction

  function automatic logic [24:0] tick_step(input logic [24:0] v);
    logic [24:0] d;
    d = v - 25'd1;
    tick_step = d | (v & 25'h1000000);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < NCPU; i++) begin
      @(negedge clk);
      reg_addr = addr_of(i);
      #1;
      check(req, 32'(reg_rdata), 32'(model[i]));
    end
  endtask

  task automatic write_reg(input logic [11:0] a, input logic [24:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    for (int i = 0; i < NCPU; i++)
      if (a == addr_of(i)) model[i] = {1'b0, d[23:0]};
  endtask

  // One tick; optionally a write lands in the cycle of the counter update.
  task automatic do_tick(input bit with_wr, input int wi, input logic [24:0] wd,
                         input string req);
    logic [3:0] exp_set;
    exp_set = '0;
    @(negedge clk);
    tick_in = 1'b1;
    @(posedge clk);            // edge k: first sample
    @(posedge clk);            // edge k+1
    if (with_wr) begin
      @(negedge clk);
      reg_addr = addr_of(wi); reg_wdata = wd; reg_wr = 1'b1;
    end
    @(posedge clk);            // edge k+2: update
    @(negedge clk);
    reg_wr = 1'b0;
    for (int i = 0; i < NCPU; i++) begin
      if (with_wr && i == wi) begin
        model[i] = {1'b0, wd[23:0]};
      end else if (cpu_present[i]) begin
        model[i] = tick_step(model[i]);
        exp_set[i] = model[i][24];
      end
    end
    check({req, " R9 R3 pulse"}, 32'(timer_set), 32'(exp_set));
    @(negedge clk);
    check("R3 one-cycle pulse", 32'(timer_set), 32'h0);
    tick_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 falling edge no pulse", 32'(timer_set), 32'h0);
    read_all({req, " R2 value"});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick_in = 1'b0; cpu_present = 4'hF;
    reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    for (int i = 0; i < NCPU; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state
    check("R8 timer_set reset", 32'(timer_set), 32'h0);
    read_all("R8 reset value");

    // R1: bit 24 of write data is dropped
    write_reg(addr_of(0), 25'h1ABCDEF);
    write_reg(addr_of(1), 25'h0000002);
    write_reg(addr_of(2), 25'h0000000);
    write_reg(addr_of(3), 25'h0FFFFFF);
    read_all("R1 R5 write/read");

    // R5: unmapped address ignored and reads zero
    write_reg(12'h400, 25'h0000055);
    @(negedge clk); reg_addr = 12'h400; #1;
    check("R5 unmapped read", 32'(reg_rdata), 32'h0);
    read_all("R5 unmapped write ignored");

    // R2/R3: CPU2 at zero wraps on first tick; CPU1 after three
    do_tick(1'b0, 0, '0, "R2 wrap");
    do_tick(1'b0, 0, '0, "R2 count");
    do_tick(1'b0, 0, '0, "R2 second wrap");
    do_tick(1'b0, 0, '0, "R2 sticky");

    // R1: write clears overflow
    write_reg(addr_of(2), 25'h1000003);
    read_all("R1 overflow cleared");

    // R4: holding tick high gives one tick only
    @(negedge clk); tick_in = 1'b1;
    repeat (10) @(negedge clk);
    for (int i = 0; i < NCPU; i++) model[i] = tick_step(model[i]);
    read_all("R4 held level one tick");
    tick_in = 1'b0;
    repeat (4) @(negedge clk);
    read_all("R4 falling level ignored");

    // R6: absent CPUs frozen
    cpu_present = 4'b0101;
    do_tick(1'b0, 0, '0, "R6 absent");
    cpu_present = 4'hF;

    // R7: write collides with tick on CPU1 (overflowed)
    do_tick(1'b1, 1, 25'h0000009, "R7 collision");

    // random mix
    for (int n = 0; n < 150; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4) begin
        int idx;
        logic [24:0] d;
        idx = int'($urandom_range(0, 3));
        d = ($urandom_range(0, 1) == 0) ? 25'($urandom_range(0, 5)) : 25'($urandom);
        write_reg(addr_of(idx), d);
      end else if (op < 5) begin
        cpu_present = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'hF;
      end else if (op < 6) begin
        do_tick(1'b1, int'($urandom_range(0, 3)), 25'($urandom_range(0, 3)), "R7 random collision");
      end else begin
        do_tick(1'b0, 0, '0, "R2 random tick");
      end
    end
    read_all("R2 final");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule